// File: doc/BRIEF.md
# Ternary Match Table with Reserved-Pair Write Guard

This block is a small ternary match table. Every stored key bit is encoded by two bits kept in two separate storage planes, plane 1 and plane 0. Together they say whether the entry needs a 0, needs a 1, or does not care about that key position. Each entry holds three independently writable fields: a short interface tag and two key words. Each field exists once in each plane. Entries are spread over banks: the low bits of an entry index pick the row within a bank and the upper bits pick the bank.

Software programs the table through a register-style write port, one field of one plane per write. Entries are switched on and off through a separate enable port. A lookup presents an interface tag and a two-word key. One cycle later the table reports whether any enabled entry matched and, if so, the lowest matching index.

The pair with both plane bits set is reserved and is never allowed into storage. A write that would create it at any bit of the addressed word is dropped whole, and a one-cycle event reports the drop. Software must therefore disable an entry and write zero to both planes of its fields before it stores new values.

Top module: `tcam_match_table`

## Requirements
- R1: After reset every stored plane word is zero, every entry is disabled, and `hit_o` and `wr_drop_o` are 0.
- R2: The per-bit encoding (plane 1, plane 0) is: (0,1) matches only a key bit of 0, (1,0) matches only a key bit of 1, and (0,0) matches either value.
- R3: No stored bit position ever holds plane 1 = 1 together with plane 0 = 1.
- R4: A write to one plane of one field is discarded in full, leaving both planes of that field unchanged, when the written data ANDed with the other plane's stored word of the same field is nonzero. Otherwise the word is replaced.
- R5: A write of all-zero data is always accepted.
- R6: Field select 0 addresses the tag (the low TAG_W bits of the write data), 1 addresses key word 0, and 2 addresses key word 1. Field select 3 has no effect on storage and never raises a drop. Plane select 1 writes plane 1 and plane select 0 writes plane 0. In an entry index, the low log2(ROWS_PER_BANK) bits give the row and the upper bits give the bank.
- R7: A disabled entry never hits, whatever it stores. The enable port sets or clears one entry's enable bit.
- R8: When several enabled entries match, the reported index is the lowest one.
- R9: `hit_o` and `hit_idx_o` are registered and reflect the lookup presented in the previous cycle. `hit_o` is 0 in the cycle after a cycle with no lookup.
- R10: `wr_drop_o` is high for exactly the one cycle that follows a discarded write, and is low after every other cycle.
- R11: The lookup tag must match the entry's stored tag under the same ternary encoding as the key words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Field write strobe |
| wr_idx_i | input | IDX_W | Entry index for the write |
| wr_fld_i | input | 2 | Field select: 0 tag, 1 key word 0, 2 key word 1, 3 none |
| wr_plane_i | input | 1 | Plane select: 1 or 0 |
| wr_data_i | input | KEY_W | Write data |
| ena_we_i | input | 1 | Enable-bit write strobe |
| ena_idx_i | input | IDX_W | Entry whose enable bit is written |
| ena_val_i | input | 1 | New enable value |
| lk_valid_i | input | 1 | Lookup request |
| lk_tag_i | input | TAG_W | Lookup interface tag |
| lk_key0_i | input | KEY_W | Lookup key word 0 |
| lk_key1_i | input | KEY_W | Lookup key word 1 |
| hit_o | output | 1 | Registered hit flag |
| hit_idx_o | output | IDX_W | Registered lowest matching index |
| wr_drop_o | output | 1 | One-cycle pulse after a discarded write |

## Verification
Lookup results appear one clock after the cycle in which the request is driven. The drop pulse likewise appears one clock after the write, and a write becomes visible to lookups starting with the next request. The driver stamps each expected lookup result with its due cycle and queues it. A monitor on the falling edge pops the item whose due cycle has come and compares it with the outputs. The write task checks the drop pulse on the falling edge after its write and checks it again one cycle later, so that a pulse lasting more than one cycle is also caught.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  localparam int unsigned CMP_W = 64;

  typedef enum logic [1:0] {
    FLD_TAG  = 2'd0,
    FLD_W0   = 2'd1,
    FLD_W1   = 2'd2,
    FLD_NONE = 2'd3
  } fld_e;

  // A key position fails when the entry demands 0 and sees 1 (plane 0 set),
  // or demands 1 and sees 0 (plane 1 set).
  function automatic logic ternary_miss(input logic [CMP_W-1:0] key,
                                        input logic [CMP_W-1:0] p1,
                                        input logic [CMP_W-1:0] p0);
    return |((key & p0) | (~key & p1));
  endfunction

  // A new plane word collides with the opposite plane when both have a 1
  // at the same position.
  function automatic logic pair_clash(input logic [CMP_W-1:0] new_word,
                                      input logic [CMP_W-1:0] opp_word);
    return |(new_word & opp_word);
  endfunction

endpackage

// File: rtl/tcam_wr_guard.sv
module tcam_wr_guard #(
  parameter int unsigned KEY_W = 32
) (
  input  logic [KEY_W-1:0] new_word_i,
  input  logic [KEY_W-1:0] opp_word_i,
  output logic             clash_o
);
  import tcam_pkg::*;

  always_comb begin
    clash_o = pair_clash(CMP_W'(new_word_i), CMP_W'(opp_word_i));
  end

endmodule

// File: rtl/tcam_bank.sv
module tcam_bank #(
  parameter int unsigned ROWS  = 16,
  parameter int unsigned KEY_W = 32,
  parameter int unsigned TAG_W = 4,
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [ROW_W-1:0] wr_row_i,
  input  logic [1:0]       wr_fld_i,
  input  logic             wr_plane_i,
  input  logic [KEY_W-1:0] wr_data_i,
  output logic             drop_o,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic [KEY_W-1:0] lk_key0_i,
  input  logic [KEY_W-1:0] lk_key1_i,
  output logic [ROWS-1:0]  match_o
);
  import tcam_pkg::*;

  logic [TAG_W-1:0] tg_p1 [ROWS];
  logic [TAG_W-1:0] tg_p0 [ROWS];
  logic [KEY_W-1:0] w0_p1 [ROWS];
  logic [KEY_W-1:0] w0_p0 [ROWS];
  logic [KEY_W-1:0] w1_p1 [ROWS];
  logic [KEY_W-1:0] w1_p0 [ROWS];

  logic [KEY_W-1:0] new_word;
  logic [KEY_W-1:0] opp_word;
  logic             clash;
  logic             fld_real;
  logic             wr_take;

  always_comb begin
    new_word = wr_data_i;
    opp_word = '0;
    unique case (fld_e'(wr_fld_i))
      FLD_TAG: begin
        new_word = KEY_W'(wr_data_i[TAG_W-1:0]);
        opp_word = wr_plane_i ? KEY_W'(tg_p0[wr_row_i]) : KEY_W'(tg_p1[wr_row_i]);
      end
      FLD_W0:  opp_word = wr_plane_i ? w0_p0[wr_row_i] : w0_p1[wr_row_i];
      FLD_W1:  opp_word = wr_plane_i ? w1_p0[wr_row_i] : w1_p1[wr_row_i];
      default: opp_word = '0;
    endcase
  end

  tcam_wr_guard #(.KEY_W(KEY_W)) guard_i (
    .new_word_i (new_word),
    .opp_word_i (opp_word),
    .clash_o    (clash)
  );

  assign fld_real = (wr_fld_i != 2'(FLD_NONE));
  assign wr_take  = wr_en_i && fld_real && !clash;
  assign drop_o   = wr_en_i && fld_real && clash;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < int'(ROWS); r++) begin
        tg_p1[r] <= '0;
        tg_p0[r] <= '0;
        w0_p1[r] <= '0;
        w0_p0[r] <= '0;
        w1_p1[r] <= '0;
        w1_p0[r] <= '0;
      end
    end else if (wr_take) begin
      unique case (fld_e'(wr_fld_i))
        FLD_TAG: if (wr_plane_i) tg_p1[wr_row_i] <= new_word[TAG_W-1:0];
                 else            tg_p0[wr_row_i] <= new_word[TAG_W-1:0];
        FLD_W0:  if (wr_plane_i) w0_p1[wr_row_i] <= new_word;
                 else            w0_p0[wr_row_i] <= new_word;
        FLD_W1:  if (wr_plane_i) w1_p1[wr_row_i] <= new_word;
                 else            w1_p0[wr_row_i] <= new_word;
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int r = 0; r < int'(ROWS); r++) begin
      match_o[r] = !ternary_miss(CMP_W'(lk_tag_i), CMP_W'(tg_p1[r]), CMP_W'(tg_p0[r]))
                && !ternary_miss(CMP_W'(lk_key0_i), CMP_W'(w0_p1[r]), CMP_W'(w0_p0[r]))
                && !ternary_miss(CMP_W'(lk_key1_i), CMP_W'(w1_p1[r]), CMP_W'(w1_p0[r]));
    end
  end

  for (genvar r = 0; r < int'(ROWS); r++) begin : g_row_chk
    // R3: the reserved pair never reaches storage
    a_r3_no_reserved_pair: assert property (@(posedge clk) disable iff (!rst_n)
      ((tg_p1[r] & tg_p0[r]) == '0) && ((w0_p1[r] & w0_p0[r]) == '0)
      && ((w1_p1[r] & w1_p0[r]) == '0));

    // R4: a discarded write leaves the row untouched
    a_r4_drop_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_o && (wr_row_i == ROW_W'(r))) |=>
        ($stable(tg_p1[r]) && $stable(tg_p0[r]) && $stable(w0_p1[r])
         && $stable(w0_p0[r]) && $stable(w1_p1[r]) && $stable(w1_p0[r])));
  end

endmodule

// File: rtl/tcam_prio_pick.sv
module tcam_prio_pick #(
  parameter int unsigned N = 32,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [N-1:0]     vec_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o
);

  logic             any;
  logic [IDX_W-1:0] first;

  always_comb begin
    any   = 1'b0;
    first = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any   = 1'b1;
        first = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o     <= 1'b0;
      hit_idx_o <= '0;
    end else begin
      hit_o     <= vld_i && any;
      hit_idx_o <= (vld_i && any) ? first : '0;
    end
  end

  // R9: no request, no hit in the next cycle
  a_r9_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !hit_o);

  // R8: entry 0 matching always wins
  a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && vec_i[0]) |=> (hit_o && hit_idx_o == '0));

endmodule

// File: rtl/tcam_match_table.sv
module tcam_match_table #(
  parameter int unsigned ROWS_PER_BANK = 16,
  parameter int unsigned NUM_BANKS     = 2,
  parameter int unsigned KEY_W         = 32,
  parameter int unsigned TAG_W         = 4,
  localparam int unsigned ROW_W   = $clog2(ROWS_PER_BANK),
  localparam int unsigned BANK_W  = $clog2(NUM_BANKS),
  localparam int unsigned ENTRIES = ROWS_PER_BANK * NUM_BANKS,
  localparam int unsigned IDX_W   = ROW_W + BANK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [1:0]       wr_fld_i,
  input  logic             wr_plane_i,
  input  logic [KEY_W-1:0] wr_data_i,
  input  logic             ena_we_i,
  input  logic [IDX_W-1:0] ena_idx_i,
  input  logic             ena_val_i,
  input  logic             lk_valid_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic [KEY_W-1:0] lk_key0_i,
  input  logic [KEY_W-1:0] lk_key1_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic             wr_drop_o
);

  logic [ROW_W-1:0]     wr_row;
  logic [BANK_W-1:0]    wr_bank;
  logic [NUM_BANKS-1:0] bank_drop;
  logic [ENTRIES-1:0]   raw_match;
  logic [ENTRIES-1:0]   en_q;
  logic [ENTRIES-1:0]   live_match;
  logic                 drop_now;

  assign wr_row  = wr_idx_i[ROW_W-1:0];
  assign wr_bank = wr_idx_i[IDX_W-1:ROW_W];

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = wr_en_i && (wr_bank == BANK_W'(b));

    tcam_bank #(
      .ROWS  (ROWS_PER_BANK),
      .KEY_W (KEY_W),
      .TAG_W (TAG_W)
    ) bank_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (bank_wr),
      .wr_row_i   (wr_row),
      .wr_fld_i   (wr_fld_i),
      .wr_plane_i (wr_plane_i),
      .wr_data_i  (wr_data_i),
      .drop_o     (bank_drop[b]),
      .lk_tag_i   (lk_tag_i),
      .lk_key0_i  (lk_key0_i),
      .lk_key1_i  (lk_key1_i),
      .match_o    (raw_match[b*ROWS_PER_BANK +: ROWS_PER_BANK])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (ena_we_i) begin
      en_q[ena_idx_i] <= ena_val_i;
    end
  end

  assign live_match = raw_match & en_q;
  assign drop_now   = |bank_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_drop_o <= 1'b0;
    else        wr_drop_o <= drop_now;
  end

  tcam_prio_pick #(.N(ENTRIES)) pick_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld_i     (lk_valid_i),
    .vec_i     (live_match),
    .hit_o     (hit_o),
    .hit_idx_o (hit_idx_o)
  );

  // R10: a drop pulse is always caused by a write in the previous cycle
  a_r10_drop_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop_o |-> $past(wr_en_i));

  // R5: zero data is never refused
  a_r5_zero_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i == '0) |=> !wr_drop_o);

  // R7: with every entry disabled, nothing hits
  a_r7_all_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_i && en_q == '0) |=> !hit_o);

endmodule

// File: tb/tcam_match_table_tb.sv
module tcam_match_table_tb_top;

  localparam int ROWS = 16;
  localparam int BANKS = 2;
  localparam int KW = 32;
  localparam int TW = 4;
  localparam int NE = ROWS * BANKS;
  localparam int IW = $clog2(NE);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [1:0]    wr_fld = '0;
  logic          wr_plane = 1'b0;
  logic [KW-1:0] wr_data = '0;
  logic          ena_we = 1'b0;
  logic [IW-1:0] ena_idx = '0;
  logic          ena_val = 1'b0;
  logic          lk_valid = 1'b0;
  logic [TW-1:0] lk_tag = '0;
  logic [KW-1:0] lk_key0 = '0;
  logic [KW-1:0] lk_key1 = '0;
  logic          hit;
  logic [IW-1:0] hit_idx;
  logic          wr_drop;

  always #2.5 clk = ~clk;

  tcam_match_table dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_fld_i(wr_fld), .wr_plane_i(wr_plane),
    .wr_data_i(wr_data),
    .ena_we_i(ena_we), .ena_idx_i(ena_idx), .ena_val_i(ena_val),
    .lk_valid_i(lk_valid), .lk_tag_i(lk_tag), .lk_key0_i(lk_key0), .lk_key1_i(lk_key1),
    .hit_o(hit), .hit_idx_o(hit_idx), .wr_drop_o(wr_drop)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Bench model: [entry][field] with field 0 tag, 1 key word 0, 2 key word 1
  logic [KW-1:0] m1 [NE][3];
  logic [KW-1:0] m0 [NE][3];
  logic          men [NE];

  typedef struct {
    int   due;
    logic exp_hit;
    int   exp_idx;
    string req;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Per-bit restatement of the ternary rule
  function automatic bit word_ok(input logic [KW-1:0] key, input logic [KW-1:0] p1,
                                 input logic [KW-1:0] p0);
    for (int i = 0; i < KW; i++) begin
      case ({p1[i], p0[i]})
        2'b01: if (key[i] != 1'b0) return 1'b0;
        2'b10: if (key[i] != 1'b1) return 1'b0;
        default: ;
      endcase
    end
    return 1'b1;
  endfunction

  task automatic do_write(input int idx, input int fld, input bit plane,
                          input logic [KW-1:0] data, input string req);
    logic [KW-1:0] d;
    logic [KW-1:0] other;
    bit clash;
    d = (fld == 0) ? (data & {{(KW-TW){1'b0}}, {TW{1'b1}}}) : data;
    clash = 1'b0;
    if (fld < 3) begin
      other = plane ? m0[idx][fld] : m1[idx][fld];
      clash = |(d & other);
      if (!clash) begin
        if (plane) m1[idx][fld] = d;
        else       m0[idx][fld] = d;
      end
    end
    wr_en = 1'b1; wr_idx = IW'(idx); wr_fld = 2'(fld); wr_plane = plane; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    check(wr_drop == clash, req, int'(wr_drop), int'(clash));
    @(negedge clk);
    check(wr_drop == 1'b0, "R10 pulse one cycle", int'(wr_drop), 0);
  endtask

  task automatic set_en(input int idx, input bit v);
    ena_we = 1'b1; ena_idx = IW'(idx); ena_val = v;
    men[idx] = v;
    @(negedge clk);
    ena_we = 1'b0;
  endtask

  task automatic clear_entry(input int idx);
    for (int f = 0; f < 3; f++) begin
      do_write(idx, f, 1'b1, '0, "R5 zero write plane1");
      do_write(idx, f, 1'b0, '0, "R5 zero write plane0");
    end
  endtask

  task automatic lookup(input logic [TW-1:0] tg, input logic [KW-1:0] k0,
                        input logic [KW-1:0] k1, input string req);
    exp_t e;
    e.exp_hit = 1'b0;
    e.exp_idx = 0;
    for (int n = NE - 1; n >= 0; n--) begin
      if (men[n] && word_ok(KW'(tg), m1[n][0], m0[n][0]) && word_ok(k0, m1[n][1], m0[n][1])
          && word_ok(k1, m1[n][2], m0[n][2])) begin
        e.exp_hit = 1'b1;
        e.exp_idx = n;
      end
    end
    e.due = cyc + 1;
    e.req = req;
    sb.push_back(e);
    lk_valid = 1'b1; lk_tag = tg; lk_key0 = k0; lk_key1 = k1;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  // Monitor: compare results when their due cycle arrives
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        check(hit == e.exp_hit, e.req, int'(hit), int'(e.exp_hit));
        if (e.exp_hit) check(int'(hit_idx) == e.exp_idx, e.req, int'(hit_idx), e.exp_idx);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < NE; n++) begin
      men[n] = 1'b0;
      for (int f = 0; f < 3; f++) begin
        m1[n][f] = '0;
        m0[n][f] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(hit == 1'b0, "R1 reset hit", int'(hit), 0);
    check(wr_drop == 1'b0, "R1 reset drop", int'(wr_drop), 0);
    lookup(4'h0, 32'h0, 32'h0, "R1 R7 nothing enabled");

    set_en(5, 1'b1);
    lookup(4'h3, 32'hDEAD_BEEF, 32'h1234_5678, "R2 don't-care entry hits");

    do_write(3, 1, 1'b1, 32'h0000_00A5, "R4 legal write plane1");
    do_write(3, 1, 1'b0, 32'hFFFF_FF5A, "R4 legal write plane0");
    set_en(3, 1'b1);
    lookup(4'h0, 32'h0000_00A5, 32'h0, "R8 lower index wins");
    lookup(4'h0, 32'h0000_00A4, 32'h0, "R2 exact bits mismatch");

    do_write(3, 1, 1'b1, 32'h0000_0100, "R4 reserved pair dropped");
    lookup(4'h0, 32'h0000_00A5, 32'h0, "R4 dropped write left word");
    do_write(3, 3, 1'b1, 32'hFFFF_FFFF, "R6 field 3 no drop");
    lookup(4'h0, 32'h0000_00A5, 32'h0, "R6 field 3 no effect");

    set_en(3, 1'b0);
    clear_entry(3);
    do_write(3, 1, 1'b1, 32'h0000_0100, "R5 rewrite after clear");
    set_en(3, 1'b1);
    lookup(4'h0, 32'h0000_0100, 32'h0, "R2 must-be-one bit");
    lookup(4'h0, 32'h0000_00A5, 32'h0, "R2 must-be-one missing");

    set_en(3, 1'b0);
    set_en(5, 1'b0);
    do_write(20, 0, 1'b1, 32'h0000_0009, "R11 tag plane1");
    do_write(20, 0, 1'b0, 32'hFFFF_FFF6, "R11 tag plane0 upper ignored");
    do_write(20, 2, 1'b0, 32'hFFFF_FFFF, "R6 bank1 key word 1");
    set_en(20, 1'b1);
    lookup(4'h9, 32'h5555_0000, 32'h0, "R6 R11 bank1 tag hit");
    lookup(4'h8, 32'h5555_0000, 32'h0, "R11 tag mismatch");
    lookup(4'h9, 32'h0, 32'h0000_0001, "R2 key1 bit must be 0");
    set_en(20, 1'b0);
    lookup(4'h9, 32'h0, 32'h0, "R7 disabled entry");

    @(negedge clk);
    @(negedge clk);
    check(sb.size() == 0, "R9 results drained", sb.size(), 0);
    check(hit == 1'b0, "R9 idle no hit", int'(hit), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule